// File: doc/BRIEF.md
# Selectable Baud Clock Divider

This block turns one fast reference clock (nominally 4.9152 MHz) into the timing strobes a small serial link and a memory sequencer need. A single free-running binary counter, clocked by the reference, stands in for a chain of divide-by-two stages. Each tap of that chain is not exported as a derived clock. Instead it becomes a one-cycle clock-enable pulse that fires when the lower counter bits all read one, which is the cycle before the next higher bit toggles. All logic downstream stays on the reference clock.

Three strobes leave the block. The oversampling strobe paces a serial receiver at 16 times the baud rate. The baud strobe paces a transmitter and an interrupt sequencer at 1x. A 2-bit octave code picks one of four neighbouring chain taps for the oversampling strobe, and the baud strobe is always taken four stages further down the same chain, so the two stay locked at exactly 16:1. The memory strobe comes from a fixed tap and paces a memory-cycle timing generator, whatever the octave code says.

With default parameters, octave code 0 gives the reference divided by 2 (153.6 kbaud from 4.9152 MHz), and each higher code halves that rate. The octave code is meant to be static. If it changes anyway, the strobes follow the new tap from the next pulse onward, and the counter keeps running.

Top module: `baud_tick_gen`

## Requirements
- R1: While rst_n is low, all three strobes are low, and asserting rst_n forces them low without waiting for a clock edge. After rst_n is released, strobe x is high at the k-th rising edge exactly when k is a multiple of that strobe's period.
- R2: The oversampling strobe period in reference cycles is 2^(1+sel_i): codes 0, 1, 2 and 3 give 2, 4, 8 and 16 cycles.
- R3: The baud strobe period is 16 times the oversampling period for the same code: 32, 64, 128 and 256 cycles for codes 0 to 3.
- R4: Every baud pulse coincides with an oversampling pulse. With a steady code, exactly 16 oversampling pulses fall in each interval after one baud pulse, up to and including the next.
- R5: The memory strobe has a period of 64 cycles for every value of sel_i.
- R6: Every strobe pulse is exactly one reference cycle wide.
- R7: A change of sel_i takes effect at the next rising edge without a reset. The strobes then follow the tap of the new code on the same running count, and the memory strobe keeps its phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock (nominally 4.9152 MHz) |
| rst_n | input | 1 | Asynchronous active-low reset; its release must be synchronous to clk |
| sel_i | input | 2 | Octave code choosing the oversampling and baud taps |
| ovs_tick_o | output | 1 | One-cycle enable at 16x the baud rate, for the receiver |
| baud_tick_o | output | 1 | One-cycle enable at the baud rate, for the transmitter and interrupt sequencer |
| mem_tick_o | output | 1 | One-cycle enable from the fixed tap, for the memory-cycle timing generator |

## Verification
The embedded assertions check three things on every cycle: the counter advances by exactly one, every baud pulse lands on an oversampling pulse, and no strobe stays high for two cycles in a row. These properties hold whatever octave code is applied. The periods, the first-pulse position after reset, the 16-pulse count between baud pulses, and the way the taps follow a code change can only be shown by the bench scenarios. The bench compares each strobe on every cycle against a model based on the number of edges since reset, under directed runs of all four codes and a seeded random sequence of code changes.

// File: rtl/baud_div_pkg.sv
package baud_div_pkg;

  // Registered strobe set leaving the divider
  typedef struct packed {
    logic ovs;
    logic baud;
    logic mem;
  } tick_set_t;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/baud_div_counter.sv
module baud_div_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [CNT_W-1:0] cnt_o
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  // next-state: free-running binary count, wraps naturally
  always_comb begin
    cnt_d = cnt_q + {{(CNT_W-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o = cnt_q;

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (cnt_q == CNT_W'($past(cnt_q) + 1'b1))); // R2

endmodule

// File: rtl/baud_div_carry.sv
module baud_div_carry #(
  parameter int CNT_W = 8
) (
  input  logic [CNT_W-1:0] cnt_i,
  output logic [CNT_W-1:0] ones_o
);

  // ones_o[n] is high when cnt_i[n:0] are all ones, i.e. bit n+1
  // toggles on the next edge: that is the tap of period 2^(n+1).
  assign ones_o[0] = cnt_i[0];

  for (genvar n = 1; n < CNT_W; n++) begin : g_chain
    assign ones_o[n] = ones_o[n-1] & cnt_i[n];
  end

endmodule

// File: rtl/baud_div_tap_sel.sv
module baud_div_tap_sel
  import baud_div_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int FIRST_SHIFT = 1,
  parameter int NUM_OCT     = 4,
  parameter int OVS_LOG     = 4,
  parameter int MEM_SHIFT   = 6,
  localparam int SEL_W      = (NUM_OCT > 1) ? $clog2(NUM_OCT) : 1,
  localparam int IDX_W      = (CNT_W > 1) ? $clog2(CNT_W) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [CNT_W-1:0] ones_i,
  output tick_set_t        ticks_o
);

  logic [IDX_W-1:0] ovs_idx;
  logic [IDX_W-1:0] baud_idx;
  tick_set_t        ticks_d;
  tick_set_t        ticks_q;

  // next-state: same octave for both selections, baud sits OVS_LOG stages deeper
  always_comb begin
    ovs_idx      = IDX_W'(FIRST_SHIFT - 1) + IDX_W'(sel_i);
    baud_idx     = ovs_idx + IDX_W'(OVS_LOG);
    ticks_d.ovs  = ones_i[ovs_idx];
    ticks_d.baud = ones_i[baud_idx];
    ticks_d.mem  = ones_i[MEM_SHIFT-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ticks_q <= '0;
    end else begin
      ticks_q <= ticks_d;
    end
  end

  assign ticks_o = ticks_q;

  AST_BAUD_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    ticks_q.baud |-> ticks_q.ovs); // R4

  AST_OVS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    ticks_q.ovs |=> !ticks_q.ovs); // R6

  AST_BAUD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    ticks_q.baud |=> !ticks_q.baud); // R6

  AST_MEM_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    ticks_q.mem |=> !ticks_q.mem); // R6

endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
  import baud_div_pkg::*;
#(
  parameter int FIRST_SHIFT = 1,
  parameter int NUM_OCT     = 4,
  parameter int OVS_LOG     = 4,
  parameter int MEM_SHIFT   = 6,
  localparam int SEL_W      = (NUM_OCT > 1) ? $clog2(NUM_OCT) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel_i,
  output logic             ovs_tick_o,
  output logic             baud_tick_o,
  output logic             mem_tick_o
);

  localparam int CNT_W = max2(FIRST_SHIFT + NUM_OCT - 1 + OVS_LOG, MEM_SHIFT);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] ones;
  tick_set_t        ticks;

  baud_div_counter #(
    .CNT_W (CNT_W)
  ) u_counter (
    .clk   (clk),
    .rst_n (rst_n),
    .cnt_o (cnt)
  );

  baud_div_carry #(
    .CNT_W (CNT_W)
  ) u_carry (
    .cnt_i  (cnt),
    .ones_o (ones)
  );

  baud_div_tap_sel #(
    .CNT_W       (CNT_W),
    .FIRST_SHIFT (FIRST_SHIFT),
    .NUM_OCT     (NUM_OCT),
    .OVS_LOG     (OVS_LOG),
    .MEM_SHIFT   (MEM_SHIFT)
  ) u_tap_sel (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel_i   (sel_i),
    .ones_i  (ones),
    .ticks_o (ticks)
  );

  assign ovs_tick_o  = ticks.ovs;
  assign baud_tick_o = ticks.baud;
  assign mem_tick_o  = ticks.mem;

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |-> (!ovs_tick_o && !baud_tick_o && !mem_tick_o)); // R1

endmodule

// File: tb/baud_tick_gen_tb_top.sv
module baud_tick_gen_tb_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] sel;
  logic       ovs, baud, mem;

  int  checks = 0;
  int  fails  = 0;
  int  k;
  int  ovs_since;
  bit  seen_baud;
  bit  done = 1'b0;
  logic p_ovs, p_baud, p_mem;

  always #5 clk = ~clk;

  baud_tick_gen dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .sel_i       (sel),
    .ovs_tick_o  (ovs),
    .baud_tick_o (baud),
    .mem_tick_o  (mem)
  );

  function automatic int ovs_per(input logic [1:0] s);
    return 1 << (1 + int'(s));
  endfunction

  function automatic int baud_per(input logic [1:0] s);
    return ovs_per(s) * 16;
  endfunction

  function automatic logic due(input int kk, input int per);
    return ((kk % per) == 0) ? 1'b1 : 1'b0;
  endfunction

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s at k=%0d sel=%0d: actual %b expected %b", req, what, k, sel, act, exp);
    end
  endtask

  task automatic chk_int(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s at k=%0d: actual %0d expected %0d", req, what, k, act, exp);
    end
  endtask

  task automatic do_reset(input logic [1:0] s);
    sel   = s;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "ovs in reset",  ovs,  1'b0);
    chk("R1", "baud in reset", baud, 1'b0);
    chk("R1", "mem in reset",  mem,  1'b0);
    @(negedge clk);
    rst_n     = 1'b1;
    k         = 0;
    ovs_since = 0;
    seen_baud = 1'b0;
    p_ovs = 1'b0; p_baud = 1'b0; p_mem = 1'b0;
  endtask

  // One edge: sample 1 time unit after it, compare with the edge-count model.
  task automatic run_cycle(input bit lock_chk, input string rq_ovs, input string rq_baud);
    @(posedge clk);
    #1;
    k++;
    chk(rq_ovs,  "ovs tick",  ovs,  due(k, ovs_per(sel)));
    chk(rq_baud, "baud tick", baud, due(k, baud_per(sel)));
    chk("R5", "mem tick", mem, due(k, 64));
    if (p_ovs && ovs)   chk("R6", "ovs width",  1'b1, 1'b0);
    if (p_baud && baud) chk("R6", "baud width", 1'b1, 1'b0);
    if (p_mem && mem)   chk("R6", "mem width",  1'b1, 1'b0);
    if (ovs) ovs_since++;
    if (baud) begin
      chk("R4", "ovs with baud", ovs, 1'b1);
      if (lock_chk && seen_baud) chk_int("R4", "ovs per baud", ovs_since, 16);
      seen_baud = 1'b1;
      ovs_since = 0;
    end
    p_ovs = ovs; p_baud = baud; p_mem = mem;
  endtask

  initial begin
    rst_n = 1'b0;
    sel   = 2'd0;
    void'($urandom(32'd20511));

    // Directed: every octave code from reset, exact timing from the first edge
    for (int s = 0; s < 4; s++) begin
      do_reset(2'(s));
      repeat (520) run_cycle(1'b1, "R2", "R3");
    end

    // Random code changes on a running count
    do_reset(2'($urandom % 4));
    for (int seg = 0; seg < 40; seg++) begin
      int hold;
      hold = 1 + int'($urandom % 300);
      sel  = 2'($urandom % 4);
      repeat (hold) run_cycle(1'b0, "R7", "R7");
    end

    // Directed: code change right after a baud pulse, then hold
    sel = 2'd3;
    while (!baud) run_cycle(1'b0, "R7", "R7");
    sel = 2'd0;
    repeat (300) run_cycle(1'b0, "R7", "R7");

    // Asynchronous reset while a strobe is high
    sel = 2'd0;
    while (!ovs) run_cycle(1'b0, "R2", "R3");
    rst_n = 1'b0;
    #1;
    chk("R1", "ovs after async reset", ovs, 1'b0);
    chk("R1", "mem after async reset", mem, 1'b0);
    do_reset(2'd1);
    repeat (70) run_cycle(1'b1, "R1", "R1");

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish, actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule